// File: doc/BRIEF.md
# Latched 4-to-16 Decoder / Demultiplexer

This block turns a binary address into a single active-high select line out of sixteen. The address goes through a holding stage. While the capture control is high, that stage passes the live address through and the chosen output tracks it in the same cycle. While the capture control is low, the stage keeps the last address it took in, so the outputs stay put even if the address lines keep changing.

A separate active-low output enable either lets the decoded line through or forces every output low. This enable never touches the held address. If the enable is driven as a serial data stream, the block works as a 1-to-16 demultiplexer: the addressed output carries the inverted enable level.

The holding stage is built as a clocked capture, not a level-sensitive latch. A clock edge with capture high loads the address register. While capture is high, the outputs decode the live address directly. Reset clears the held address to zero.

Top module: `latched_demux16`

## Requirements
- R1: While reset is asserted and after it is released, the held address is 0. With capture low and enable low, only output bit 0 is high until an address is captured.
- R2: Output bit k is the one that goes high for address value k. Address bit 0 is the least significant bit.
- R3: No more than one output bit is high in any cycle, including while the address changes with capture high.
- R4: While capture (`le_i`) is high, the output decodes the live address in the same cycle.
- R5: Each clock edge with capture high loads the address register. While capture is low, the register keeps its value and the outputs ignore changes on the address lines.
- R6: With the active-low enable (`en_n_i`) low, exactly one output is high: the one indexed by the address in effect.
- R7: With the enable high, all outputs are low, whatever the address and capture levels.
- R8: The enable has no effect on the held address. Toggling it while capture is low leaves the same output selected once it returns low, and capture still loads while the enable is high.
- R9: In demultiplexer use, the addressed output equals the inverse of the enable level from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address capture register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the held address |
| addr_i | input | ADDR_W (4) | Binary address; bit 0 is the least significant |
| le_i | input | 1 | Capture control: high makes the stage transparent and loads it on each edge |
| en_n_i | input | 1 | Active-low output enable, also the serial data input in demultiplexer use |
| sel_o | output | 2**ADDR_W (16) | One-hot active-high select lines |

## Verification
The bench builds the block with its default address width of four bits, so there are sixteen outputs. At that size every address value can be walked exhaustively, both in transparent mode and from the held register. It can also pin down the exact bit position of every output. The stimulus table interleaves capture, hold and enable changes, so hold-while-the-address-moves, capture-under-disable and serial demultiplexing are each seen against a known held value. A mid-run reset shows that the held address returns to zero.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  localparam int unsigned DEF_ADDR_W = 4;

  // Number of select lines for a given address width.
  function automatic int unsigned line_count(input int unsigned aw);
    return 32'd1 << aw;
  endfunction

  // True when line k is the one named by address value a.
  function automatic logic line_hit(input logic [31:0] a, input int unsigned k);
    return (a == k);
  endfunction

endpackage

// File: rtl/dmx_addr_latch.sv
module dmx_addr_latch #(
  parameter int unsigned ADDR_W = dmx_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] held_o,
  output logic [ADDR_W-1:0] eff_o
);

  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (le_i) held_q <= addr_i;
  end

  // transparent path while capture is high, stored value otherwise
  always_comb begin
    if (le_i) eff_o = addr_i;
    else      eff_o = held_q;
  end

  assign held_o = held_q;

  // R5
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_i |=> (held_q == $past(addr_i)));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le_i |=> $stable(held_q));

endmodule

// File: rtl/dmx_decode.sv
module dmx_decode #(
  parameter int unsigned ADDR_W = dmx_pkg::DEF_ADDR_W,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_OUT-1:0]  hot_o
);

  logic [31:0] addr_wide;
  assign addr_wide = 32'(addr_i);

  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    assign hot_o[k] = dmx_pkg::line_hit(addr_wide, k);
  end

endmodule

// File: rtl/dmx_gate.sv
module dmx_gate #(
  parameter int unsigned N_OUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n_i,
  input  logic [N_OUT-1:0] hot_i,
  output logic [N_OUT-1:0] sel_o
);

  always_comb begin
    if (en_n_i) sel_o = '0;
    else        sel_o = hot_i;
  end

  // R7
  blank_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |-> (sel_o == '0));

  // R6
  single_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_n_i |-> ($countones(sel_o) == 1));

  // R3
  at_most_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

endmodule

// File: rtl/latched_demux16.sv
module latched_demux16 #(
  parameter int unsigned ADDR_W = dmx_pkg::DEF_ADDR_W,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              le_i,
  input  logic              en_n_i,
  output logic [N_OUT-1:0]  sel_o
);

  // named internal events for the checks below
  logic [ADDR_W-1:0] addr_held;
  logic [ADDR_W-1:0] addr_eff;
  logic [N_OUT-1:0]  line_hot;

  dmx_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .le_i   (le_i),
    .addr_i (addr_i),
    .held_o (addr_held),
    .eff_o  (addr_eff)
  );

  dmx_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_eff),
    .hot_o  (line_hot)
  );

  dmx_gate #(.N_OUT(N_OUT)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_n_i (en_n_i),
    .hot_i  (line_hot),
    .sel_o  (sel_o)
  );

  // R4
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_i && !en_n_i) |-> sel_o[addr_i]);

  // R2
  held_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && !en_n_i) |-> sel_o[addr_held]);

  // R8
  enable_no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && en_n_i) |=> (addr_held == $past(addr_held)));

  // R9
  demux_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o[addr_eff] == !en_n_i);

endmodule

// File: tb/latched_demux16_bench.sv
module latched_demux16_bench;

  localparam int unsigned AW = 4;
  localparam int unsigned NO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          le = 1'b0;
  logic          en_n = 1'b0;
  logic [NO-1:0] sel;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  latched_demux16 u_latched_demux16 (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (addr),
    .le_i   (le),
    .en_n_i (en_n),
    .sel_o  (sel)
  );

  // {le, en_n, addr[3:0], expect_active, expect_index[3:0]}
  localparam int NV = 16;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd5,  1'b1, 4'd0},   // R1 reset value held
    {1'b1, 1'b0, 4'd5,  1'b1, 4'd5},   // R4 transparent, loads 5
    {1'b0, 1'b0, 4'd9,  1'b1, 4'd5},   // R5 hold
    {1'b0, 1'b1, 4'd9,  1'b0, 4'd0},   // R7 blank
    {1'b0, 1'b0, 4'd3,  1'b1, 4'd5},   // R8 back on, same line
    {1'b1, 1'b0, 4'd15, 1'b1, 4'd15},  // R4 top line
    {1'b1, 1'b0, 4'd0,  1'b1, 4'd0},   // R4 bottom line
    {1'b0, 1'b0, 4'd15, 1'b1, 4'd0},   // R5 hold 0
    {1'b1, 1'b1, 4'd10, 1'b0, 4'd0},   // R8 capture while off
    {1'b0, 1'b0, 4'd2,  1'b1, 4'd10},  // R8 captured 10
    {1'b0, 1'b1, 4'd2,  1'b0, 4'd0},   // R9 data bit 1 -> line low
    {1'b0, 1'b0, 4'd2,  1'b1, 4'd10},  // R9 data bit 0 -> line high
    {1'b1, 1'b0, 4'd1,  1'b1, 4'd1},   // R2 LSB
    {1'b0, 1'b0, 4'd0,  1'b1, 4'd1},   // R5 hold 1
    {1'b1, 1'b0, 4'd8,  1'b1, 4'd8},   // R2 MSB
    {1'b0, 1'b0, 4'd7,  1'b1, 4'd8}    // R5 hold 8
  };

  task automatic check_sel(input string req, input logic [NO-1:0] exp);
    total++;
    if (sel !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, sel, exp);
    end
    total++;
    if (!$onehot0(sel)) begin
      bad++;
      $display("FAIL R3 got=%h exp=at most one bit", sel);
    end
  endtask

  task automatic drive(input logic l, input logic e, input logic [AW-1:0] a);
    @(negedge clk);
    #1;
    le = l;
    en_n = e;
    addr = a;
    #2;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [NO-1:0] e;
    repeat (3) @(posedge clk);
    #1;
    check_sel("R1", 16'h0001);      // held zero during reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8:5]);
      e = VEC[i][4] ? (16'h0001 << VEC[i][3:0]) : 16'h0000;
      check_sel($sformatf("vec%0d", i), e);
    end

    // R2 R4: every address in transparent mode
    for (int a = 0; a < NO; a++) begin
      drive(1'b1, 1'b0, AW'(a));
      check_sel("R2", 16'h0001 << a);
    end

    // R5: load 6, then sweep the address lines with capture low
    drive(1'b1, 1'b0, 4'd6);
    for (int a = 0; a < NO; a++) begin
      drive(1'b0, 1'b0, AW'(a));
      check_sel("R5", 16'h0040);
    end

    // R8: toggle enable with capture low, line must return to 6
    for (int t = 0; t < 4; t++) begin
      drive(1'b0, 1'b1, AW'(t + 11));
      check_sel("R7", 16'h0000);
      drive(1'b0, 1'b0, AW'(t + 3));
      check_sel("R8", 16'h0040);
    end

    // R9: serial bitstream on enable to line 12
    drive(1'b1, 1'b0, 4'd12);
    for (int b = 0; b < 8; b++) begin
      logic bit_v;
      bit_v = ((8'hA6 >> b) & 1) != 0;
      drive(1'b0, bit_v, 4'd0);
      check_sel("R9", bit_v ? 16'h0000 : 16'h1000);
    end

    // R1: reset in mid-run clears held address
    drive(1'b0, 1'b0, 4'd9);
    check_sel("R5", 16'h1000);
    rst_n = 1'b0;
    #1;
    check_sel("R1", 16'h0001);
    drive(1'b0, 1'b0, 4'd9);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 4'd4);
    check_sel("R1", 16'h0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule